// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block sits beside a dispatch-group tracker and watches the memory accesses that enter the current group. Each store that issues leaves a record in a small table: a base-pointer identifier, a signed byte offset and an access size in bytes. When a later load in the same group presents its own base, offset and size, every record is compared with it at once. If any recorded store may touch the bytes the load reads, the block raises a flag. The group tracker turns that flag into a no-op hazard, so the load is pushed into a later group.

The table holds a fixed number of stores (four by default). Once it is full, further stores in the group go unrecorded. A pulse on the group-end input empties the table. The overlap flag is combinational from the load inputs and the table as it stood at the start of the cycle. A store presented in the same cycle as a load is therefore not visible to that load.

Top module: `sld_overlap_detector`

## Requirements
- R1: After reset, and whenever no store is recorded in the current group, `overlap_o` is 0 for any load.
- R2: A load whose base and offset both equal those of a recorded store is flagged, whatever the two sizes are, including size 0.
- R3: With equal bases and the store offset below the load offset, the flag is 1 exactly when store offset + store size > load offset. For example, an 8-byte store at 100 hits a load at 107 but not one at 108.
- R4: With equal bases and the store offset at or above the load offset, the flag is 1 exactly when load offset + load size > store offset. For example, a load at 96 hits a store at 100 with size 5 but not with size 4.
- R5: A load whose base differs from the base of every recorded store is never flagged.
- R6: A load is checked only when `ld_valid_i` and `ld_memop_i` are both 1; otherwise `overlap_o` is 0.
- R7: At most ENTRIES stores (default 4) are recorded per group. A store that arrives when the table is full leaves no trace, and a load that matches only that store is not flagged.
- R8: `grp_end_i` empties the table at the clock edge. A store presented in the same cycle as `grp_end_i` is discarded. A load presented in that cycle is still checked against the table contents before the clear.
- R9: A store and a load presented in the same cycle are compared using the table state from before that cycle. The new store affects loads from the next cycle on.
- R10: Offsets are two's-complement signed, so negative offsets compare in signed order. The end-of-range sums are formed one bit wider than the offset, so a range that runs past the largest offset does not wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties the table |
| grp_end_i | input | 1 | Dispatch group ends at this edge |
| st_valid_i | input | 1 | A store issues this cycle |
| st_base_i | input | BASE_W | Store base-pointer identifier |
| st_off_i | input | OFF_W | Store signed byte offset |
| st_size_i | input | SIZE_W | Store size in bytes |
| ld_valid_i | input | 1 | A load is queried this cycle |
| ld_memop_i | input | 1 | Load carries memory-operand information |
| ld_base_i | input | BASE_W | Load base-pointer identifier |
| ld_off_i | input | OFF_W | Load signed byte offset |
| ld_size_i | input | SIZE_W | Load size in bytes |
| overlap_o | output | 1 | Load may overlap a recorded store |

## Verification
The bench probes each range boundary one byte inside and one byte outside. A design with an off-by-one comparison (`>=` in place of `>`) would flag loads that only abut a store. It also uses a zero-size store at an exactly equal offset, which a design without the exact-match term would miss. Negative offsets and a store that runs past the largest positive offset are included: an unsigned comparison would order the negative pair wrongly, and a sum at offset width would wrap and miss the hit. Further tests fill the table and present a fifth store, put a store in the same cycle as a group end, and put a store and a load in the same cycle. A design that overwrites the last entry, records across the clear, or forwards the incoming store would raise the flag where it must stay low.

// File: rtl/sld_pkg.sv
package sld_pkg;
   localparam int unsigned SLD_ENTRIES_DEF = 4;
   localparam int unsigned SLD_BASE_W_DEF  = 16;
   localparam int unsigned SLD_OFF_W_DEF   = 64;
   localparam int unsigned SLD_SIZE_W_DEF  = 16;

   // relation of one recorded store to the queried load
   typedef enum logic [1:0] {
      REL_NONE     = 2'd0,
      REL_EXACT    = 2'd1,
      REL_ST_BELOW = 2'd2,
      REL_LD_BELOW = 2'd3
   } sld_rel_e;
endpackage

// File: rtl/sld_range_cmp.sv
module sld_range_cmp
   import sld_pkg::*;
#(
   parameter int unsigned BASE_W = SLD_BASE_W_DEF,
   parameter int unsigned OFF_W  = SLD_OFF_W_DEF,
   parameter int unsigned SIZE_W = SLD_SIZE_W_DEF
) (
   input  logic [BASE_W-1:0] e_base_i,
   input  logic [OFF_W-1:0]  e_off_i,
   input  logic [SIZE_W-1:0] e_size_i,
   input  logic [BASE_W-1:0] q_base_i,
   input  logic [OFF_W-1:0]  q_off_i,
   input  logic [SIZE_W-1:0] q_size_i,
   output sld_rel_e          rel_o,
   output logic              hit_o
);
   localparam int unsigned EXT_W = OFF_W + 1;
   localparam int unsigned PAD_W = EXT_W - SIZE_W;

   logic signed [EXT_W-1:0] e_lo, q_lo, e_hi, q_hi, e_len, q_len;
   logic base_eq, off_eq, e_below;

   always_comb begin
      e_lo  = {e_off_i[OFF_W-1], e_off_i};
      q_lo  = {q_off_i[OFF_W-1], q_off_i};
      e_len = {{PAD_W{1'b0}}, e_size_i};
      q_len = {{PAD_W{1'b0}}, q_size_i};
      e_hi  = e_lo + e_len;
      q_hi  = q_lo + q_len;
      base_eq = (e_base_i == q_base_i);
      off_eq  = (e_off_i == q_off_i);
      e_below = (e_lo < q_lo);
   end

   always_comb begin
      rel_o = REL_NONE;
      hit_o = 1'b0;
      if (base_eq) begin
         if (off_eq) begin
            rel_o = REL_EXACT;
            hit_o = 1'b1;
         end else if (e_below) begin
            rel_o = REL_ST_BELOW;
            hit_o = (e_hi > q_lo);
         end else begin
            rel_o = REL_LD_BELOW;
            hit_o = (q_hi > e_lo);
         end
      end
   end
endmodule

// File: rtl/sld_store_table.sv
module sld_store_table
   import sld_pkg::*;
#(
   parameter int unsigned ENTRIES = SLD_ENTRIES_DEF,
   parameter int unsigned BASE_W  = SLD_BASE_W_DEF,
   parameter int unsigned OFF_W   = SLD_OFF_W_DEF,
   parameter int unsigned SIZE_W  = SLD_SIZE_W_DEF,
   localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clr_i,
   input  logic                            wr_i,
   input  logic [BASE_W-1:0]               wr_base_i,
   input  logic [OFF_W-1:0]                wr_off_i,
   input  logic [SIZE_W-1:0]               wr_size_i,
   output logic [ENTRIES-1:0][BASE_W-1:0]  base_o,
   output logic [ENTRIES-1:0][OFF_W-1:0]   off_o,
   output logic [ENTRIES-1:0][SIZE_W-1:0]  size_o,
   output logic [ENTRIES-1:0]              live_o
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ENTRIES);

   logic [CNT_W-1:0] fill_q;
   logic             accept;

   assign accept = wr_i && !clr_i && (fill_q != CNT_FULL);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         fill_q <= '0;
      end else if (accept) begin
         fill_q <= fill_q + CNT_W'(1);
      end
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam logic [CNT_W-1:0] SLOT = CNT_W'(i);
      logic we;
      assign we        = accept && (fill_q == SLOT);
      assign live_o[i] = (fill_q > SLOT);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_o[i] <= '0;
            off_o[i]  <= '0;
            size_o[i] <= '0;
         end else if (we) begin
            base_o[i] <= wr_base_i;
            off_o[i]  <= wr_off_i;
            size_o[i] <= wr_size_i;
         end
      end
   end
endmodule

// File: rtl/sld_overlap_detector.sv
module sld_overlap_detector
   import sld_pkg::*;
#(
   parameter int unsigned ENTRIES = SLD_ENTRIES_DEF,
   parameter int unsigned BASE_W  = SLD_BASE_W_DEF,
   parameter int unsigned OFF_W   = SLD_OFF_W_DEF,
   parameter int unsigned SIZE_W  = SLD_SIZE_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grp_end_i,
   input  logic              st_valid_i,
   input  logic [BASE_W-1:0] st_base_i,
   input  logic [OFF_W-1:0]  st_off_i,
   input  logic [SIZE_W-1:0] st_size_i,
   input  logic              ld_valid_i,
   input  logic              ld_memop_i,
   input  logic [BASE_W-1:0] ld_base_i,
   input  logic [OFF_W-1:0]  ld_off_i,
   input  logic [SIZE_W-1:0] ld_size_i,
   output logic              overlap_o
);
   if (ENTRIES < 1) begin : g_bad_entries
      $error("sld_overlap_detector: ENTRIES must be at least 1");
   end
   if (SIZE_W >= OFF_W) begin : g_bad_size
      $error("sld_overlap_detector: SIZE_W must be narrower than OFF_W");
   end
   if (BASE_W < 1 || OFF_W < 2) begin : g_bad_width
      $error("sld_overlap_detector: BASE_W or OFF_W too small");
   end

   logic [ENTRIES-1:0][BASE_W-1:0] tb_base;
   logic [ENTRIES-1:0][OFF_W-1:0]  tb_off;
   logic [ENTRIES-1:0][SIZE_W-1:0] tb_size;
   logic [ENTRIES-1:0]             tb_live;
   logic [ENTRIES-1:0]             ent_hit;
   logic                           query;

   sld_store_table #(
      .ENTRIES (ENTRIES),
      .BASE_W  (BASE_W),
      .OFF_W   (OFF_W),
      .SIZE_W  (SIZE_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (grp_end_i),
      .wr_i      (st_valid_i),
      .wr_base_i (st_base_i),
      .wr_off_i  (st_off_i),
      .wr_size_i (st_size_i),
      .base_o    (tb_base),
      .off_o     (tb_off),
      .size_o    (tb_size),
      .live_o    (tb_live)
   );

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      sld_rel_e rel;
      logic     raw_hit;
      sld_range_cmp #(
         .BASE_W (BASE_W),
         .OFF_W  (OFF_W),
         .SIZE_W (SIZE_W)
      ) u_cmp (
         .e_base_i (tb_base[i]),
         .e_off_i  (tb_off[i]),
         .e_size_i (tb_size[i]),
         .q_base_i (ld_base_i),
         .q_off_i  (ld_off_i),
         .q_size_i (ld_size_i),
         .rel_o    (rel),
         .hit_o    (raw_hit)
      );
      assign ent_hit[i] = raw_hit && tb_live[i] && (rel != REL_NONE);
   end

   assign query     = ld_valid_i && ld_memop_i && tb_live[0];
   assign overlap_o = query && (|ent_hit);
endmodule

// File: rtl/sld_overlap_chk.sv
module sld_overlap_chk #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned BASE_W  = 16,
   parameter int unsigned OFF_W   = 64,
   parameter int unsigned SIZE_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              grp_end_i,
   input logic              st_valid_i,
   input logic [BASE_W-1:0] st_base_i,
   input logic [OFF_W-1:0]  st_off_i,
   input logic [SIZE_W-1:0] st_size_i,
   input logic              ld_valid_i,
   input logic              ld_memop_i,
   input logic [BASE_W-1:0] ld_base_i,
   input logic [OFF_W-1:0]  ld_off_i,
   input logic [SIZE_W-1:0] ld_size_i,
   input logic              overlap_o
);
   localparam int unsigned CW = $clog2(ENTRIES + 1);
   logic [CW-1:0] seen_q;
   logic          first_take;

   assign first_take = st_valid_i && !grp_end_i && (seen_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || grp_end_i) seen_q <= '0;
      else if (st_valid_i && seen_q != CW'(ENTRIES)) seen_q <= seen_q + CW'(1);
   end

   AST_EMPTY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q == '0) |-> !overlap_o); // R1

   AST_QUERY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_valid_i || !ld_memop_i) |-> !overlap_o); // R6

   AST_CLEARED_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      $past(grp_end_i) |-> !overlap_o); // R8

   AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(first_take) && ld_valid_i && ld_memop_i &&
       ld_base_i == $past(st_base_i) && ld_off_i == $past(st_off_i)) |-> overlap_o); // R2
endmodule

bind sld_overlap_detector sld_overlap_chk #(
   .ENTRIES (ENTRIES),
   .BASE_W  (BASE_W),
   .OFF_W   (OFF_W),
   .SIZE_W  (SIZE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .grp_end_i  (grp_end_i),
   .st_valid_i (st_valid_i),
   .st_base_i  (st_base_i),
   .st_off_i   (st_off_i),
   .st_size_i  (st_size_i),
   .ld_valid_i (ld_valid_i),
   .ld_memop_i (ld_memop_i),
   .ld_base_i  (ld_base_i),
   .ld_off_i   (ld_off_i),
   .ld_size_i  (ld_size_i),
   .overlap_o  (overlap_o)
);

// File: tb/sld_overlap_detector_tb.sv
module sld_overlap_detector_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        grp_end_i = 1'b0;
   logic        st_valid_i = 1'b0;
   logic [15:0] st_base_i = '0;
   logic [63:0] st_off_i = '0;
   logic [15:0] st_size_i = '0;
   logic        ld_valid_i = 1'b0;
   logic        ld_memop_i = 1'b0;
   logic [15:0] ld_base_i = '0;
   logic [63:0] ld_off_i = '0;
   logic [15:0] ld_size_i = '0;
   logic        overlap_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   sld_overlap_detector u_dut (
      .clk(clk), .rst_n(rst_n), .grp_end_i(grp_end_i),
      .st_valid_i(st_valid_i), .st_base_i(st_base_i), .st_off_i(st_off_i), .st_size_i(st_size_i),
      .ld_valid_i(ld_valid_i), .ld_memop_i(ld_memop_i), .ld_base_i(ld_base_i),
      .ld_off_i(ld_off_i), .ld_size_i(ld_size_i), .overlap_o(overlap_o)
   );

   task automatic check(input logic exp, input string tag);
      checks++;
      if (overlap_o !== exp) begin
         fails++;
         $display("FAIL %s: overlap=%b expected %b", tag, overlap_o, exp);
      end
   endtask

   task automatic store_op(input logic [15:0] b, input logic [63:0] o, input logic [15:0] s);
      @(negedge clk);
      st_valid_i = 1'b1; st_base_i = b; st_off_i = o; st_size_i = s;
      @(negedge clk);
      st_valid_i = 1'b0;
   endtask

   task automatic end_grp();
      @(negedge clk); grp_end_i = 1'b1;
      @(negedge clk); grp_end_i = 1'b0;
   endtask

   task automatic probe(input logic [15:0] b, input logic [63:0] o, input logic [15:0] s,
                        input logic mem, input logic exp, input string tag);
      @(negedge clk);
      ld_valid_i = 1'b1; ld_memop_i = mem; ld_base_i = b; ld_off_i = o; ld_size_i = s;
      #2 check(exp, tag);
      ld_valid_i = 1'b0; ld_memop_i = 1'b0;
   endtask

   task automatic t_reset();
      probe(16'd5, 64'd100, 16'd4, 1'b1, 1'b0, "R1 empty after reset");
   endtask

   task automatic t_exact_and_base();
      end_grp();
      store_op(16'd5, 64'd100, 16'd8);
      probe(16'd5, 64'd100, 16'd4, 1'b1, 1'b1, "R2 exact base+offset");
      probe(16'd6, 64'd100, 16'd4, 1'b1, 1'b0, "R5 other base");
      probe(16'd5, 64'd100, 16'd4, 1'b0, 1'b0, "R6 no memop info");
   endtask

   task automatic t_ranges();
      probe(16'd5, 64'd107, 16'd1, 1'b1, 1'b1, "R3 last store byte");
      probe(16'd5, 64'd108, 16'd1, 1'b1, 1'b0, "R3 just past store");
      probe(16'd5, 64'd96,  16'd4, 1'b1, 1'b0, "R4 load abuts store");
      probe(16'd5, 64'd96,  16'd5, 1'b1, 1'b1, "R4 load reaches store");
   endtask

   task automatic t_zero_size();
      end_grp();
      store_op(16'd3, 64'd40, 16'd0);
      probe(16'd3, 64'd40, 16'd0, 1'b1, 1'b1, "R2 zero size exact");
      probe(16'd3, 64'd39, 16'd1, 1'b1, 1'b0, "R4 zero size store below edge");
   endtask

   task automatic t_signed();
      end_grp();
      store_op(16'd2, -64'sd16, 16'd8);
      probe(16'd2, -64'sd9, 16'd1, 1'b1, 1'b1, "R10 negative offset inside");
      probe(16'd2, -64'sd8, 16'd1, 1'b1, 1'b0, "R10 negative offset past end");
      end_grp();
      store_op(16'd2, 64'h7FFF_FFFF_FFFF_FFF8, 16'd16);
      probe(16'd2, 64'h7FFF_FFFF_FFFF_FFFF, 16'd1, 1'b1, 1'b1, "R10 no wrap at top");
   endtask

   task automatic t_capacity();
      end_grp();
      for (int i = 0; i < 4; i++) store_op(16'(10 + i), 64'd0, 16'd4);
      store_op(16'd14, 64'd0, 16'd4);
      probe(16'd14, 64'd0, 16'd4, 1'b1, 1'b0, "R7 fifth store dropped");
      probe(16'd13, 64'd0, 16'd4, 1'b1, 1'b1, "R7 fourth store kept");
      end_grp();
      probe(16'd10, 64'd0, 16'd4, 1'b1, 1'b0, "R8 cleared at group end");
   endtask

   task automatic t_same_cycle();
      end_grp();
      @(negedge clk);
      st_valid_i = 1'b1; st_base_i = 16'd7; st_off_i = 64'd200; st_size_i = 16'd4;
      ld_valid_i = 1'b1; ld_memop_i = 1'b1; ld_base_i = 16'd7; ld_off_i = 64'd200; ld_size_i = 16'd4;
      #2 check(1'b0, "R9 same-cycle store invisible");
      @(negedge clk);
      st_valid_i = 1'b0;
      #2 check(1'b1, "R9 store visible next cycle");
      // load during the group end still sees the table
      @(negedge clk);
      grp_end_i = 1'b1;
      #2 check(1'b1, "R8 load in group-end cycle");
      @(negedge clk);
      grp_end_i = 1'b0;
      #2 check(1'b0, "R8 table empty after end");
      ld_valid_i = 1'b0; ld_memop_i = 1'b0;
      // store in group-end cycle is discarded
      @(negedge clk);
      st_valid_i = 1'b1; grp_end_i = 1'b1;
      @(negedge clk);
      st_valid_i = 1'b0; grp_end_i = 1'b0;
      probe(16'd7, 64'd200, 16'd4, 1'b1, 1'b0, "R8 store with group end dropped");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_exact_and_base();
      t_ranges();
      t_zero_size();
      t_signed();
      t_capacity();
      t_same_cycle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule